// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset reference into a 20-bit physical memory address. For each request it forms a 16-bit effective offset. The offset comes either from a fixed pointer register or from any sum of an optional base register, an optional index register and an optional 8- or 16-bit displacement. The block then picks the segment register that applies, shifts that segment left by four bits and adds the offset.

The choice of segment depends on the access class (instruction fetch, stack, data, string destination) and on which base register a data access uses. A segment-override prefix can replace the default, but only for data accesses. One request is accepted per clock, and its results appear on registered outputs exactly one cycle later. Instruction decode and the register file sit outside the block and present their values on the input pins.

Top module: `addr_gen`

## Requirements
- R1: A request presented with `req_valid_i`=1 produces `res_valid_o`=1 together with its results on the following clock. With `req_valid_i`=0, `res_valid_o` is 0 on the following clock. While `rst_ni` is low, `res_valid_o`, `seg_sel_o`, `ea_o` and `pa_o` are all 0.
- R2: For a data access, `amode_i` holds three fields. Bits [5:4] select the base: 1=BX, 2=BP, 0 or 3=none. Bits [3:2] select the index: 1=SI, 2=DI, 0 or 3=none. Bits [1:0] select the displacement: 1=8-bit, 2=16-bit, 0 or 3=none. The offset `ea_o` is the sum of the selected parts, and an unselected part contributes 0.
- R3: An 8-bit displacement uses only `disp_i[7:0]`, sign-extended to 16 bits. `disp_i[15:8]` has no effect in that mode.
- R4: The offset sum wraps modulo 2^16.
- R5: `pa_o` equals (segment value × 16 + `ea_o`) modulo 2^20, where the segment value is the register named by `seg_sel_o`. Segment codes are 0=ES, 1=CS, 2=SS, 3=DS.
- R6: Access class 0 (fetch) yields segment CS and offset `ip_i`. The mode, displacement and override have no effect on it.
- R7: Access class 1 (stack) yields segment SS and offset `sp_i`. The override has no effect on it.
- R8: Access class 2 (data) with no override defaults to SS when the base field is BP, and to DS otherwise. This includes the direct, SI-only and DI-only forms.
- R9: Access class 2 with `ovr_en_i`=1 uses the segment coded on `ovr_seg_i` in place of the default.
- R10: Access class 3 (string destination) yields segment ES and offset `di_i`, whatever the override and mode inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| acc_class_i | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| amode_i | input | 6 | Base/index/displacement selection |
| ovr_en_i | input | 1 | Segment override present |
| ovr_seg_i | input | 2 | Override segment code |
| disp_i | input | 16 | Displacement |
| bx_i | input | 16 | Base register BX |
| bp_i | input | 16 | Base pointer BP |
| si_i | input | 16 | Source index |
| di_i | input | 16 | Destination index |
| sp_i | input | 16 | Stack pointer |
| ip_i | input | 16 | Instruction pointer |
| cs_i | input | 16 | Code segment |
| ds_i | input | 16 | Data segment |
| ss_i | input | 16 | Stack segment |
| es_i | input | 16 | Extra segment |
| res_valid_o | output | 1 | Result valid |
| seg_sel_o | output | 2 | Segment code used |
| ea_o | output | 16 | Effective offset |
| pa_o | output | 20 | Physical address |

## Verification
The hardest cases to reach are the two wrap points. The offset has to overflow 16 bits, and the shifted segment plus the offset has to carry past bit 19. Both need register values near the top of the range, which random values rarely hit. Directed requests therefore set BX=FFFF with SI=0002, and CS=FFFF with IP=FFFF. A negative 8-bit displacement whose upper displacement byte holds garbage shows that only the low byte is used and that it is sign-extended. Overrides are also placed on fetch, stack and string-destination requests to show that those classes ignore them.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
  typedef enum logic [1:0] {SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3} seg_e;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_STACK = 2'd1, ACC_DATA = 2'd2, ACC_SDST = 2'd3} acc_e;
  typedef enum logic [1:0] {BASE_NONE = 2'd0, BASE_BX = 2'd1, BASE_BP = 2'd2, BASE_RSV = 2'd3} base_e;
  typedef enum logic [1:0] {IDX_NONE = 2'd0, IDX_SI = 2'd1, IDX_DI = 2'd2, IDX_RSV = 2'd3} idx_e;
  typedef enum logic [1:0] {DSP_NONE = 2'd0, DSP_S8 = 2'd1, DSP_W16 = 2'd2, DSP_RSV = 2'd3} dsp_e;

  typedef struct packed {
    base_e base;
    idx_e  idx;
    dsp_e  dsp;
  } amode_t;
endpackage

// File: rtl/addr_gen_ofs.sv
module addr_gen_ofs
  import addr_gen_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int DSP_S = 8
) (
  input  acc_e             acc_i,
  input  amode_t           mode_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] sp_i,
  input  logic [OFS_W-1:0] ip_i,
  output logic [OFS_W-1:0] ea_o
);
  localparam int EXT_W = OFS_W - DSP_S;

  logic [OFS_W-1:0] base_v, idx_v, dsp_v, data_ea;

  always_comb begin
    unique case (mode_i.base)
      BASE_BX: base_v = bx_i;
      BASE_BP: base_v = bp_i;
      default: base_v = '0;
    endcase
    unique case (mode_i.idx)
      IDX_SI:  idx_v = si_i;
      IDX_DI:  idx_v = di_i;
      default: idx_v = '0;
    endcase
    unique case (mode_i.dsp)
      DSP_S8:  dsp_v = {{EXT_W{disp_i[DSP_S-1]}}, disp_i[DSP_S-1:0]};
      DSP_W16: dsp_v = disp_i;
      default: dsp_v = '0;
    endcase
  end

  // carry out of the top bit is dropped: modulo 2^OFS_W
  assign data_ea = base_v + idx_v + dsp_v;

  always_comb begin
    unique case (acc_i)
      ACC_FETCH: ea_o = ip_i;
      ACC_STACK: ea_o = sp_i;
      ACC_DATA:  ea_o = data_ea;
      default:   ea_o = di_i;
    endcase
  end
endmodule

// File: rtl/addr_gen_seg.sv
module addr_gen_seg
  import addr_gen_pkg::*;
(
  input  acc_e  acc_i,
  input  base_e base_i,
  input  logic  ovr_en_i,
  input  seg_e  ovr_seg_i,
  output seg_e  seg_o
);
  seg_e data_dflt;

  assign data_dflt = (base_i == BASE_BP) ? SEG_SS : SEG_DS;

  always_comb begin
    unique case (acc_i)
      ACC_FETCH: seg_o = SEG_CS;
      ACC_STACK: seg_o = SEG_SS;
      ACC_DATA:  seg_o = ovr_en_i ? ovr_seg_i : data_dflt;
      default:   seg_o = SEG_ES;
    endcase
  end
endmodule

// File: rtl/addr_gen_phys.sv
module addr_gen_phys #(
  parameter int OFS_W  = 16,
  parameter int SEG_SH = 4,
  localparam int PA_W  = OFS_W + SEG_SH
) (
  input  logic [OFS_W-1:0] seg_val_i,
  input  logic [OFS_W-1:0] ea_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [PA_W-1:0] seg_ext, ea_ext;

  assign seg_ext = {seg_val_i, {SEG_SH{1'b0}}};
  assign ea_ext  = {{SEG_SH{1'b0}}, ea_i};
  assign pa_o    = seg_ext + ea_ext;
endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import addr_gen_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int SEG_SH = 4,
  parameter int DSP_S  = 8,
  localparam int PA_W  = OFS_W + SEG_SH,
  localparam int NSEG  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       acc_class_i,
  input  logic [5:0]       amode_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_seg_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] sp_i,
  input  logic [OFS_W-1:0] ip_i,
  input  logic [OFS_W-1:0] cs_i,
  input  logic [OFS_W-1:0] ds_i,
  input  logic [OFS_W-1:0] ss_i,
  input  logic [OFS_W-1:0] es_i,
  output logic             res_valid_o,
  output logic [1:0]       seg_sel_o,
  output logic [OFS_W-1:0] ea_o,
  output logic [PA_W-1:0]  pa_o
);
  acc_e             acc;
  amode_t           mode;
  seg_e             seg_d;
  logic [OFS_W-1:0] ea_d, seg_val;
  logic [PA_W-1:0]  pa_d;
  logic [OFS_W-1:0] seg_tab [NSEG];

  assign acc  = acc_e'(acc_class_i);
  assign mode = amode_t'(amode_i);

  // table indexed by segment code
  assign seg_tab[SEG_ES] = es_i;
  assign seg_tab[SEG_CS] = cs_i;
  assign seg_tab[SEG_SS] = ss_i;
  assign seg_tab[SEG_DS] = ds_i;

  addr_gen_ofs #(.OFS_W(OFS_W), .DSP_S(DSP_S)) u_ofs (
    .acc_i (acc),
    .mode_i(mode),
    .disp_i(disp_i),
    .bx_i  (bx_i),
    .bp_i  (bp_i),
    .si_i  (si_i),
    .di_i  (di_i),
    .sp_i  (sp_i),
    .ip_i  (ip_i),
    .ea_o  (ea_d)
  );

  addr_gen_seg u_seg (
    .acc_i    (acc),
    .base_i   (mode.base),
    .ovr_en_i (ovr_en_i),
    .ovr_seg_i(seg_e'(ovr_seg_i)),
    .seg_o    (seg_d)
  );

  assign seg_val = seg_tab[seg_d];

  addr_gen_phys #(.OFS_W(OFS_W), .SEG_SH(SEG_SH)) u_phys (
    .seg_val_i(seg_val),
    .ea_i     (ea_d),
    .pa_o     (pa_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      seg_sel_o   <= '0;
      ea_o        <= '0;
      pa_o        <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        seg_sel_o <= seg_d;
        ea_o      <= ea_d;
        pa_o      <= pa_d;
      end
    end
  end
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
  parameter int OFS_W  = 16,
  parameter int SEG_SH = 4,
  localparam int PA_W  = OFS_W + SEG_SH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       acc_class_i,
  input logic [5:0]       amode_i,
  input logic             ovr_en_i,
  input logic [1:0]       ovr_seg_i,
  input logic [OFS_W-1:0] ip_i,
  input logic [OFS_W-1:0] sp_i,
  input logic [OFS_W-1:0] di_i,
  input logic [OFS_W-1:0] cs_i,
  input logic [OFS_W-1:0] ds_i,
  input logic [OFS_W-1:0] ss_i,
  input logic [OFS_W-1:0] es_i,
  input logic             res_valid_o,
  input logic [1:0]       seg_sel_o,
  input logic [OFS_W-1:0] ea_o,
  input logic [PA_W-1:0]  pa_o
);
  logic [OFS_W-1:0] cs_q, ds_q, ss_q, es_q, seg_q;

  always_ff @(posedge clk_i) begin
    cs_q <= cs_i;
    ds_q <= ds_i;
    ss_q <= ss_i;
    es_q <= es_i;
  end

  always_comb begin
    case (seg_sel_o)
      2'd0:    seg_q = es_q;
      2'd1:    seg_q = cs_q;
      2'd2:    seg_q = ss_q;
      default: seg_q = ds_q;
    endcase
  end

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  a_r5_phys_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> pa_o == PA_W'({seg_q, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, ea_o}));
  a_r6_fetch_cs_ip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_class_i == 2'd0) |=> (seg_sel_o == 2'd1 && ea_o == $past(ip_i)));
  a_r7_stack_ss_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_class_i == 2'd1) |=> (seg_sel_o == 2'd2 && ea_o == $past(sp_i)));
  a_r8_bp_default_ss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_class_i == 2'd2 && !ovr_en_i && amode_i[5:4] == 2'd2) |=> seg_sel_o == 2'd2);
  a_r9_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_class_i == 2'd2 && ovr_en_i) |=> seg_sel_o == $past(ovr_seg_i));
  a_r10_sdst_es_di: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_class_i == 2'd3) |=> (seg_sel_o == 2'd0 && ea_o == $past(di_i)));
endmodule

bind addr_gen addr_gen_chk #(.OFS_W(OFS_W), .SEG_SH(SEG_SH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .acc_class_i(acc_class_i),
  .amode_i    (amode_i),
  .ovr_en_i   (ovr_en_i),
  .ovr_seg_i  (ovr_seg_i),
  .ip_i       (ip_i),
  .sp_i       (sp_i),
  .di_i       (di_i),
  .cs_i       (cs_i),
  .ds_i       (ds_i),
  .ss_i       (ss_i),
  .es_i       (es_i),
  .res_valid_o(res_valid_o),
  .seg_sel_o  (seg_sel_o),
  .ea_o       (ea_o),
  .pa_o       (pa_o)
);

// File: tb/addr_gen_test.sv
module addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  acc_class_i = '0;
  logic [5:0]  amode_i = '0;
  logic        ovr_en_i = 1'b0;
  logic [1:0]  ovr_seg_i = '0;
  logic [15:0] disp_i = '0, bx_i = '0, bp_i = '0, si_i = '0, di_i = '0, sp_i = '0, ip_i = '0;
  logic [15:0] cs_i = '0, ds_i = '0, ss_i = '0, es_i = '0;
  logic        res_valid_o;
  logic [1:0]  seg_sel_o;
  logic [15:0] ea_o;
  logic [19:0] pa_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          vld;
    logic [1:0]  seg;
    logic [15:0] ea;
    logic [19:0] pa;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  addr_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .acc_class_i(acc_class_i),
    .amode_i(amode_i), .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i), .disp_i(disp_i),
    .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i), .sp_i(sp_i), .ip_i(ip_i),
    .cs_i(cs_i), .ds_i(ds_i), .ss_i(ss_i), .es_i(es_i),
    .res_valid_o(res_valid_o), .seg_sel_o(seg_sel_o), .ea_o(ea_o), .pa_o(pa_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] seg_value(input logic [1:0] code);
    case (code)
      2'd0:    return es_i;
      2'd1:    return cs_i;
      2'd2:    return ss_i;
      default: return ds_i;
    endcase
  endfunction

  // drive one request (or idle) on a falling edge and queue the expectation
  task automatic issue(input bit v, input logic [1:0] cls, input logic [5:0] md,
                       input bit oe, input logic [1:0] os, input string tag);
    exp_t e;
    logic [15:0] b, x, d;
    @(negedge clk);
    req_valid_i = v; acc_class_i = cls; amode_i = md; ovr_en_i = oe; ovr_seg_i = os;
    e.vld = v; e.tag = tag;
    if (cls == 2'd0) begin e.seg = 2'd1; e.ea = ip_i; end
    else if (cls == 2'd1) begin e.seg = 2'd2; e.ea = sp_i; end
    else if (cls == 2'd3) begin e.seg = 2'd0; e.ea = di_i; end
    else begin
      b = (md[5:4] == 2'd1) ? bx_i : (md[5:4] == 2'd2) ? bp_i : 16'h0;
      x = (md[3:2] == 2'd1) ? si_i : (md[3:2] == 2'd2) ? di_i : 16'h0;
      d = (md[1:0] == 2'd1) ? {{8{disp_i[7]}}, disp_i[7:0]} : (md[1:0] == 2'd2) ? disp_i : 16'h0;
      e.ea  = b + x + d;
      e.seg = oe ? os : ((md[5:4] == 2'd2) ? 2'd2 : 2'd3);
    end
    e.pa = (20'(seg_value(e.seg)) << 4) + 20'(e.ea);
    exp_q.push_back(e);
  endtask

  // monitor: sample 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, " R1 valid"}, 32'(res_valid_o), 32'(e.vld));
      if (e.vld) begin
        chk({e.tag, " seg"}, 32'(seg_sel_o), 32'(e.seg));
        chk({e.tag, " ea"}, 32'(ea_o), 32'(e.ea));
        chk({e.tag, " R5 pa"}, 32'(pa_o), 32'(e.pa));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cs_i = 16'h1000; ds_i = 16'h2000; ss_i = 16'h3000; es_i = 16'h4000;
    bx_i = 16'h0100; bp_i = 16'h0200; si_i = 16'h0030; di_i = 16'h0004;
    sp_i = 16'hFFFE; ip_i = 16'h0123; disp_i = 16'hAB80;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset valid", 32'(res_valid_o), 0);
    chk("R1 reset ea", 32'(ea_o), 0);
    chk("R1 reset pa", 32'(pa_o), 0);
    chk("R1 reset seg", 32'(seg_sel_o), 0);
    @(negedge clk); rst_ni = 1'b1;

    issue(1, 2'd0, 6'h3F, 1, 2'd3, "R6 fetch ignores mode/override");
    issue(1, 2'd1, 6'h00, 1, 2'd0, "R7 stack ignores override");
    issue(1, 2'd3, 6'h15, 1, 2'd3, "R10 sdst ignores override");
    issue(1, 2'd2, 6'h02, 0, 2'd0, "R2 R8 direct disp16 DS");
    issue(1, 2'd2, 6'h15, 0, 2'd0, "R2 R3 BX+SI+disp8 neg");
    issue(1, 2'd2, 6'h29, 0, 2'd0, "R3 R8 BP+DI+disp8 SS");
    issue(1, 2'd2, 6'h20, 1, 2'd3, "R9 BP with DS override");
    issue(1, 2'd2, 6'h10, 1, 2'd0, "R9 BX with ES override");
    issue(1, 2'd2, 6'h04, 0, 2'd0, "R8 SI only DS");
    issue(1, 2'd2, 6'h3F, 0, 2'd0, "R2 reserved fields zero");
    issue(0, 2'd2, 6'h10, 0, 2'd0, "R1 idle");
    issue(1, 2'd2, 6'h18, 0, 2'd0, "R2 BX+DI");
    @(negedge clk);
    disp_i = 16'h007F;
    issue(1, 2'd2, 6'h01, 0, 2'd0, "R3 disp8 positive");
    @(negedge clk);
    bx_i = 16'hFFFF; si_i = 16'h0002;
    issue(1, 2'd2, 6'h14, 0, 2'd0, "R4 offset wrap");
    @(negedge clk);
    cs_i = 16'hFFFF; ip_i = 16'hFFFF;
    issue(1, 2'd0, 6'h00, 0, 2'd0, "R5 physical wrap");
    issue(0, 2'd0, 6'h00, 0, 2'd0, "R1 idle");

    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      {bx_i, bp_i} = $urandom; {si_i, di_i} = $urandom; {sp_i, ip_i} = $urandom;
      {cs_i, ds_i} = $urandom; {ss_i, es_i} = $urandom; disp_i = 16'($urandom);
      issue(1'($urandom), 2'($urandom), 6'($urandom), 1'($urandom), 2'($urandom), "R2 random");
    end
    issue(0, 2'd0, 6'h00, 0, 2'd0, "R1 idle");
    repeat (4) @(posedge clk);
    #3;
    chk("R1 queue drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule